// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block turns a stream of packed pixel words into the drive waveforms of a monochrome passive-matrix LCD. It pulls one 8-bit word per shift-clock period from a ready/valid fetch port and presents it on the panel data bus. It produces a half-rate shift clock, a line latch pulse after each line, a frame start pulse for the row driver, an AC drive frame signal and a panel enable.

Two scan organisations are supported. In single-panel mode every fetched byte holds eight consecutive pixels of one line. In dual-panel mode the bus is split: bits 3:0 carry four pixels of the upper half and bits 7:4 four pixels of the lower half, and both halves are scanned together. Every frame ends with two retrace lines that carry no data but still issue a latch pulse, so that cascaded row drivers keep a two-line gap. Panel width and height are parameters. A two-bit mode input selects dual-panel operation (bit 0, captured only while reset is high) and drives the panel enable (bit 1).

Top module: `lcd_panel_timing`

## Requirements
- R1: `lcd_shclk` is high for exactly one system clock at a time and low for at least one. `lcd_data` changes only on the edge where `lcd_shclk` rises, so the data are unchanged at its falling edge.
- R2: In single-panel mode (mode bit 0 = 0) each visible line carries PANEL_W/8 shift-clock pulses. The bytes appear on `lcd_data` in the order they were accepted from the fetch port.
- R3: In dual-panel mode (mode bit 0 = 1) each visible line carries PANEL_W/4 pulses. Fetch bits 3:0 (upper half) appear on `lcd_data[3:0]` and fetch bits 7:4 (lower half) on `lcd_data[7:4]` in the same period.
- R4: After the last pulse of a line, `lcd_latch` goes high for exactly two system clocks, and `lcd_shclk` is low for the whole time.
- R5: A frame has PANEL_H+2 lines in single-panel mode and PANEL_H/2+2 in dual-panel mode. The last two lines are retrace lines with no shift pulses, each closed by a latch pulse.
- R6: `lcd_frame_start` is high on the falling edge of `lcd_latch` that closes the second retrace line, and on no other falling edge of `lcd_latch`.
- R7: `lcd_ac` is 0 after reset and inverts exactly on the `lcd_latch` falling edge at which `lcd_frame_start` is high, once per frame.
- R8: `lcd_enable` is 0 while `rst` is high; otherwise it follows mode bit 1 with one clock of delay.
- R9: While the fetch port offers no word, no shift pulse is produced and `lcd_data` holds. A shift pulse rises only on the clock after a ready/valid handshake, and no word is skipped or repeated.
- R10: The panel mode is taken from mode bit 0 while `rst` is high. A change of that bit after reset has no effect on the line length or the frame length.
- R11: While `rst` is high, `lcd_shclk`, `lcd_latch`, `lcd_frame_start`, `lcd_ac`, `lcd_enable`, `pix_ready` and `lcd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Bit 0: dual-panel select (captured in reset); bit 1: panel enable |
| pix_valid | input | 1 | Fetch port offers a pixel word |
| pix_data | input | 8 | Packed pixel word |
| pix_ready | output | 1 | Generator accepts a word on this clock |
| lcd_shclk | output | 1 | Data shift clock, panel samples on its falling edge |
| lcd_latch | output | 1 | Line latch / row advance pulse |
| lcd_frame_start | output | 1 | Active-high frame start for the row driver |
| lcd_ac | output | 1 | AC drive frame signal |
| lcd_data | output | 8 | Panel data bus |
| lcd_enable | output | 1 | Panel enable |

## Verification
The bench sweeps whole frames in both scan modes, with and without gaps in the fetch stream. It counts shift pulses per line against the mode's arithmetic, so a design that used the wrong divisor, or shifted during retrace lines, would produce a wrong count at some latch. At every latch fall it compares frame start and the AC signal with its own line index; an off-by-one frame start would move the row scan by a line, and a late AC toggle would show at the wrong latch edge. Fetch stalls show up as skipped or repeated words in the data sequence. A mode bit flipped mid-run shows whether the mode is wrongly re-read, because the line length would then change.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    // Horizontal phases of one scan line
    typedef enum logic [1:0] {
        H_SHIFT = 2'd0,   // shifting words (or idling on a retrace line)
        H_LATCH = 2'd1,   // setup cycle then latch pulse
        H_POST  = 2'd2    // hold cycle after the latch falls
    } hstate_t;

    localparam int unsigned RETRACE_LINES = 2;
    localparam int unsigned LATCH_HIGH    = 2;
    localparam int unsigned BUS_W         = 8;

    // Column-driver side of the interface
    typedef struct packed {
        logic             shclk;
        logic             latch;
        logic [BUS_W-1:0] data;
    } col_drive_t;

    function automatic int unsigned shifts_per_line(int unsigned width, bit dual);
        return dual ? width / 4 : width / 8;
    endfunction

    function automatic int unsigned lines_per_frame(int unsigned height, bit dual);
        return (dual ? height / 2 : height) + RETRACE_LINES;
    endfunction

endpackage

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
    import lcd_tim_pkg::*;
#(
    parameter int unsigned PANEL_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dual,
    input  logic             blank,
    input  logic             pix_valid,
    input  logic [BUS_W-1:0] pix_data,
    output logic             pix_ready,
    output col_drive_t       drv,
    output logic             latch_end,
    output logic             line_done
);

    localparam int unsigned WMAX = shifts_per_line(PANEL_W, 1'b1);
    localparam int unsigned CW   = (WMAX > 1) ? $clog2(WMAX) : 1;
    localparam logic [CW-1:0] LAST_S = CW'(shifts_per_line(PANEL_W, 1'b0) - 1);
    localparam logic [CW-1:0] LAST_D = CW'(WMAX - 1);
    localparam logic [1:0]    LCNT_END = 2'(LATCH_HIGH);

    hstate_t          st;
    logic             ph;
    logic [CW-1:0]    wcnt;
    logic [1:0]       lcnt;
    logic             shclk_q;
    logic [BUS_W-1:0] data_q;
    logic [CW-1:0]    wlast;

    assign wlast     = dual ? LAST_D : LAST_S;
    assign pix_ready = !rst && (st == H_SHIFT) && !ph && !blank;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= H_SHIFT;
            ph      <= 1'b0;
            wcnt    <= '0;
            lcnt    <= '0;
            shclk_q <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (st)
                H_SHIFT: begin
                    if (!ph) begin
                        if (blank) begin
                            ph <= 1'b1;
                        end else if (pix_valid) begin
                            ph      <= 1'b1;
                            shclk_q <= 1'b1;
                            data_q  <= pix_data;
                        end
                    end else begin
                        ph      <= 1'b0;
                        shclk_q <= 1'b0;
                        if (wcnt == wlast) begin
                            wcnt <= '0;
                            lcnt <= '0;
                            st   <= H_LATCH;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                H_LATCH: begin
                    if (lcnt == LCNT_END) st <= H_POST;
                    else                  lcnt <= lcnt + 1'b1;
                end
                H_POST:  st <= H_SHIFT;
                default: st <= H_SHIFT;
            endcase
        end
    end

    always_comb begin
        drv.shclk = shclk_q;
        drv.latch = (st == H_LATCH) && (lcnt != 2'd0);
        drv.data  = data_q;
    end

    assign latch_end = (st == H_LATCH) && (lcnt == LCNT_END);
    assign line_done = (st == H_POST);

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_tim_pkg::*;
#(
    parameter int unsigned PANEL_H = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dual,
    input  logic line_done,
    input  logic latch_end,
    output logic blank,
    output logic frame_start,
    output logic ac
);

    localparam int unsigned LMAX = lines_per_frame(PANEL_H, 1'b0);
    localparam int unsigned LW   = $clog2(LMAX + 1);
    localparam logic [LW-1:0] VIS_S = LW'(PANEL_H);
    localparam logic [LW-1:0] VIS_D = LW'(PANEL_H / 2);
    localparam logic [LW-1:0] TAIL  = LW'(RETRACE_LINES - 1);

    logic [LW-1:0] line_q;
    logic [LW-1:0] vis;
    logic [LW-1:0] last;
    logic          ac_q;

    assign vis         = dual ? VIS_D : VIS_S;
    assign last        = vis + TAIL;
    assign blank       = (line_q >= vis);
    assign frame_start = (line_q == last);
    assign ac          = ac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            ac_q   <= 1'b0;
        end else begin
            if (line_done) line_q <= frame_start ? '0 : line_q + 1'b1;
            if (latch_end && frame_start) ac_q <= ~ac_q;
        end
    end

endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing
    import lcd_tim_pkg::*;
#(
    parameter int unsigned PANEL_W = 32,
    parameter int unsigned PANEL_H = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic             pix_valid,
    input  logic [BUS_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             lcd_shclk,
    output logic             lcd_latch,
    output logic             lcd_frame_start,
    output logic             lcd_ac,
    output logic [BUS_W-1:0] lcd_data,
    output logic             lcd_enable
);

    logic       dual_q;
    logic       en_q;
    logic       blank;
    logic       latch_end;
    logic       line_done;
    col_drive_t drv;

    // Mode is sampled only during reset; enable follows bit 1
    always_ff @(posedge clk) begin
        if (rst) begin
            dual_q <= cfg_mode[0];
            en_q   <= 1'b0;
        end else begin
            en_q   <= cfg_mode[1];
        end
    end

    lcd_line_seq #(.PANEL_W(PANEL_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .dual      (dual_q),
        .blank     (blank),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .drv       (drv),
        .latch_end (latch_end),
        .line_done (line_done)
    );

    lcd_frame_seq #(.PANEL_H(PANEL_H)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .dual        (dual_q),
        .line_done   (line_done),
        .latch_end   (latch_end),
        .blank       (blank),
        .frame_start (lcd_frame_start),
        .ac          (lcd_ac)
    );

    assign lcd_shclk  = drv.shclk;
    assign lcd_latch  = drv.latch;
    assign lcd_data   = drv.data;
    assign lcd_enable = en_q;

endmodule

// File: rtl/lcd_panel_timing_chk.sv
module lcd_panel_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic       lcd_shclk,
    input logic       lcd_latch,
    input logic       lcd_frame_start,
    input logic       lcd_ac,
    input logic [7:0] lcd_data,
    input logic       lcd_enable
);

    // R1
    shclk_single_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_shclk |=> !lcd_shclk);

    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_shclk) |-> $stable(lcd_data));

    // R4
    latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_latch |-> !lcd_shclk);

    // R9
    shift_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_shclk) |-> $past(pix_valid && pix_ready));

    // R7
    ac_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lcd_ac) |-> ($fell(lcd_latch) && lcd_frame_start));

    // R8
    enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lcd_enable == $past(cfg_mode[1])));

endmodule

bind lcd_panel_timing lcd_panel_timing_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_mode        (cfg_mode),
    .pix_valid       (pix_valid),
    .pix_ready       (pix_ready),
    .lcd_shclk       (lcd_shclk),
    .lcd_latch       (lcd_latch),
    .lcd_frame_start (lcd_frame_start),
    .lcd_ac          (lcd_ac),
    .lcd_data        (lcd_data),
    .lcd_enable      (lcd_enable)
);

// File: tb/lcd_panel_timing_test.sv
`timescale 1ns/1ps
module lcd_panel_timing_test;

    localparam int W = 32;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_mode;
    logic       pix_valid;
    logic [7:0] pix_data;
    logic       pix_ready;
    logic       lcd_shclk, lcd_latch, lcd_frame_start, lcd_ac, lcd_enable;
    logic [7:0] lcd_data;

    always #4 clk = ~clk;  // 125 MHz

    lcd_panel_timing #(.PANEL_W(W), .PANEL_H(H)) uut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .lcd_shclk(lcd_shclk), .lcd_latch(lcd_latch),
        .lcd_frame_start(lcd_frame_start), .lcd_ac(lcd_ac),
        .lcd_data(lcd_data), .lcd_enable(lcd_enable)
    );

    int nchk = 0;
    int nfail = 0;

    // bench model state
    bit       mon_on = 1'b0;
    bit       stall_on = 1'b0;
    bit       dual_m;
    int       wpl, vis, lpf;
    int       line, words, lat_w, frames, cyc;
    logic [7:0] exp_w, data_prev;
    bit       sh_prev, lat_prev, ac_ref, fire_prev;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor and fetch feeder, both acting at the falling clock edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mon_on && !rst) begin
                if (lcd_shclk && !sh_prev) begin
                    chk(fire_prev, "R9 pulse without handshake", 0, 1);
                    if (dual_m)
                        chk(lcd_data[3:0] == exp_w[3:0] && lcd_data[7:4] == exp_w[7:4],
                            "R3 nibble lanes", lcd_data, exp_w);
                    else
                        chk(lcd_data == exp_w, "R2 byte order", lcd_data, exp_w);
                    exp_w = exp_w + 8'd1;
                    words++;
                end
                if (lcd_shclk && sh_prev) chk(1'b0, "R1 shclk high too long", 1, 0);
                if (!lcd_shclk && sh_prev)
                    chk(lcd_data == data_prev, "R1 data at falling edge", lcd_data, data_prev);
                if (lcd_latch && lcd_shclk) chk(1'b0, "R4 shclk during latch", 1, 0);
                if (lcd_latch && !lat_prev) begin
                    if (line < vis)
                        chk(words == wpl, dual_m ? "R3 shifts per line" : "R2 shifts per line",
                            words, wpl);
                    else
                        chk(words == 0, "R5 retrace line shifts", words, 0);
                    words = 0;
                end
                if (lcd_latch) lat_w++;
                if (!lcd_latch && lat_prev) begin
                    chk(lat_w == 2, "R4 latch width", lat_w, 2);
                    lat_w = 0;
                    chk(lcd_frame_start == (line == lpf - 1), "R6 frame start at latch fall",
                        lcd_frame_start, (line == lpf - 1));
                    chk((lcd_ac != ac_ref) == (line == lpf - 1), "R7 ac toggle",
                        lcd_ac, (line == lpf - 1) ? !ac_ref : ac_ref);
                    ac_ref = lcd_ac;
                    if (line == lpf - 1) begin
                        line = 0;
                        frames++;
                    end else begin
                        line++;
                    end
                end
                sh_prev   = lcd_shclk;
                lat_prev  = lcd_latch;
                data_prev = lcd_data;
                if (fire_prev) pix_data = pix_data + 8'd1;
                pix_valid = !(stall_on && ((cyc % 5) < 2));
                fire_prev = pix_ready && pix_valid;
            end
        end
    end

    task automatic run_mode(input bit dm, input bit stall, input bit flip);
        @(posedge clk); #2;
        rst = 1'b1;
        mon_on = 1'b0;
        pix_valid = 1'b0;
        cfg_mode = {1'b1, dm};
        @(posedge clk); @(negedge clk);
        // R11
        chk(!lcd_shclk && !lcd_latch && !lcd_frame_start && !lcd_ac && !lcd_enable
            && !pix_ready && lcd_data == 8'd0, "R11 reset state",
            {lcd_shclk, lcd_latch, lcd_frame_start, lcd_ac, lcd_enable, pix_ready}, 0);
        dual_m = dm;
        wpl = dm ? W / 4 : W / 8;
        vis = dm ? H / 2 : H;
        lpf = vis + 2;
        line = 0; words = 0; lat_w = 0; frames = 0;
        exp_w = 8'd0; data_prev = 8'd0; pix_data = 8'd0;
        sh_prev = 1'b0; lat_prev = 1'b0; ac_ref = 1'b0; fire_prev = 1'b0;
        stall_on = stall;
        pix_valid = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        mon_on = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(lcd_enable == 1'b1, "R8 enable after reset", lcd_enable, 1);
        if (flip) begin
            wait (frames >= 1);
            @(posedge clk); #2;
            cfg_mode[0] = ~cfg_mode[0];   // R10: must not change the scan
        end
        wait (frames >= 2);
        @(posedge clk); #2;
        cfg_mode[1] = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(lcd_enable == 1'b0, "R8 enable follows bit 1", lcd_enable, 0);
        if (flip) chk(frames >= 2, "R10 frames completed after flip", frames, 2);
    endtask

    initial begin
        rst = 1'b1;
        cfg_mode = 2'b00;
        pix_valid = 1'b0;
        pix_data = 8'd0;
        run_mode(1'b0, 1'b0, 1'b0);
        run_mode(1'b0, 1'b1, 1'b1);
        run_mode(1'b1, 1'b0, 1'b0);
        run_mode(1'b1, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule